// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Mode Controller

This block chooses the power mode of a self-refreshing pseudo-static RAM and decides which rows receive refresh. It samples the active-low chip enable, the active-low sleep pin, the stored sleep bit of the configuration register, and a strobe raised when a software configuration write completes. From these it reports one of three modes: active, standby, or partial-array refresh (PAR).

In active and standby mode every refresh tick refreshes the next row of the whole array. In PAR the refresh row counter is limited to a chosen fraction of the array, anchored at either the low or the high end of the address map. In that mode read and write requests are not passed on. PAR can be entered in two ways. One is to hold the sleep pin low for a qualified time. The other is a software write that sets the sleep bit. Any software write disables pin-started PAR until the next reset.

Top module: `psram_lp_ctrl`

## Requirements
- R1: After reset the mode output is active (00), `refresh_req` and `access_blocked` are 0, and pin-started PAR is enabled.
- R2: Outside PAR, the mode becomes standby (01) one cycle after `ce_n` and `sleep_n` are both sampled high. Otherwise it becomes active (00). Refresh then covers the full array.
- R3: When pin entry is enabled and `cfg_sleep_bit` is 1, the mode becomes PAR (10) at the edge that samples `sleep_n` low for the (LOW_CYCLES+1)-th consecutive time. With fewer consecutive low samples, PAR is not entered.
- R4: While `cfg_sleep_bit` is 0, holding `sleep_n` low never starts PAR.
- R5: A PAR started by the pin is left at the first edge that samples `sleep_n` high.
- R6: In PAR, `access_blocked` is 1 and `rd_go`/`wr_go` are 0 whatever `rd_req`/`wr_req` are. Outside PAR, `rd_go` equals `rd_req` and `wr_go` equals `wr_req`.
- R7: In PAR, `cfg_extent` sets the refreshed size: 000 full, 001 half, 010 quarter, 011 eighth, 100 none. Every other code means full.
- R8: `cfg_from_top` = 0 places the refreshed partition at row 0. A value of 1 places it so that it ends at the last row.
- R9: An internal offset starts at 0 after reset and advances by 1, modulo the row count, with each issued request. A tick yields `refresh_req` = 1 in the next cycle, with `refresh_row` = partition base + (offset mod partition size).
- R10: With extent "none" in PAR, a tick yields no refresh request and the offset does not move.
- R11: A software write strobe with `sw_cfg_sleep` = 1 puts the mode in PAR in the next cycle. With `sw_cfg_sleep` = 0 the next mode is standby or active per R2.
- R12: After any software write, `sleep_n` low never starts PAR until reset. A PAR started by software is not left when `sleep_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| ce_n | input | 1 | Active-low chip enable |
| sleep_n | input | 1 | Active-low sleep pin |
| cfg_sleep_bit | input | 1 | Stored sleep bit of the configuration register |
| cfg_extent | input | 3 | Refresh extent code used in PAR |
| cfg_from_top | input | 1 | Partition anchored at the high end when 1 |
| sw_cfg_wr | input | 1 | One-cycle strobe of a completed software configuration write |
| sw_cfg_sleep | input | 1 | Sleep bit value carried by that software write |
| refresh_tick | input | 1 | Refresh timing pulse |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| mode | output | 2 | 00 active, 01 standby, 10 PAR |
| refresh_req | output | 1 | Refresh request |
| refresh_row | output | ROW_W | Row to refresh |
| access_blocked | output | 1 | High while in PAR |
| rd_go | output | 1 | Read request passed on |
| wr_go | output | 1 | Write request passed on |

## Verification
The mode is registered, so it changes at the first edge that samples a stimulus. The bench drives inputs on the falling edge and reads the mode at the next falling edge. A refresh request and its row appear one edge after the tick, and each is checked at that same half-cycle point. Pin entry is probed twice: once after LOW_CYCLES low samples, where PAR must not yet hold, and once a single cycle later, where it must. The read and write gates depend only on the registered mode and are checked within the same cycle.

// File: rtl/psram_lp_pkg.sv
package psram_lp_pkg;

    typedef enum logic [1:0] {
        MODE_ACTIVE  = 2'b00,
        MODE_STANDBY = 2'b01,
        MODE_PAR     = 2'b10
    } mode_e;

    localparam logic [2:0] EXT_FULL    = 3'b000;
    localparam logic [2:0] EXT_HALF    = 3'b001;
    localparam logic [2:0] EXT_QUARTER = 3'b010;
    localparam logic [2:0] EXT_EIGHTH  = 3'b011;
    localparam logic [2:0] EXT_NONE    = 3'b100;

    // how far the full row range is divided (log2 of the divisor)
    function automatic logic [1:0] ext_shift(input logic [2:0] ext);
        case (ext)
            EXT_HALF:    return 2'd1;
            EXT_QUARTER: return 2'd2;
            EXT_EIGHTH:  return 2'd3;
            default:     return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/sleep_qual.sv
module sleep_qual #(
    parameter int LOW_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_n,
    output logic qualified
);
    localparam int CW = $clog2(LOW_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LOW_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sleep_n) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qualified = (st_q.cnt == LIMIT);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_n |=> !qualified);

endmodule

// File: rtl/mode_ctrl.sv
module mode_ctrl
    import psram_lp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ce_n,
    input  logic  sleep_n,
    input  logic  cfg_sleep_bit,
    input  logic  sw_cfg_wr,
    input  logic  sw_cfg_sleep,
    input  logic  low_qualified,
    output mode_e mode
);
    typedef struct packed {
        mode_e mode;
        logic  src_sw;
        logic  pin_en;
    } st_t;

    st_t   st_d, st_q;
    mode_e base_mode;

    always_comb begin
        st_d      = st_q;
        base_mode = (ce_n && sleep_n) ? MODE_STANDBY : MODE_ACTIVE;
        if (sw_cfg_wr) begin
            st_d.pin_en = 1'b0;
            if (sw_cfg_sleep) begin
                st_d.mode   = MODE_PAR;
                st_d.src_sw = 1'b1;
            end else begin
                st_d.mode   = base_mode;
                st_d.src_sw = 1'b0;
            end
        end else if (st_q.mode == MODE_PAR) begin
            if (!st_q.src_sw && sleep_n) begin
                st_d.mode = base_mode;
            end
        end else if (st_q.pin_en && cfg_sleep_bit && !sleep_n && low_qualified) begin
            st_d.mode   = MODE_PAR;
            st_d.src_sw = 1'b0;
        end else begin
            st_d.mode = base_mode;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_ACTIVE;
            st_q.src_sw <= 1'b0;
            st_q.pin_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode = st_q.mode;

    // R5
    pin_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_PAR && !st_q.src_sw && sleep_n && !sw_cfg_wr)
        |=> (st_q.mode != MODE_PAR));

    // R4
    sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != MODE_PAR && !cfg_sleep_bit && !sw_cfg_wr)
        |=> (st_q.mode != MODE_PAR));

    // R11
    sw_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_cfg_wr && sw_cfg_sleep) |=> (st_q.mode == MODE_PAR));

    // R12
    pin_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pin_en || sw_cfg_wr) |=> !st_q.pin_en);

endmodule

// File: rtl/refresh_gen.sv
module refresh_gen
    import psram_lp_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             in_par,
    input  logic [2:0]       extent,
    input  logic             from_top,
    output logic             req,
    output logic [ROW_W-1:0] row
);
    typedef struct packed {
        logic [ROW_W-1:0] off;
        logic [ROW_W-1:0] row;
        logic             req;
    } st_t;

    st_t              st_d, st_q;
    logic [1:0]       shift;
    logic             none_sel;
    logic [ROW_W-1:0] mask;
    logic [ROW_W-1:0] base;

    always_comb begin
        shift    = in_par ? ext_shift(extent) : 2'd0;
        none_sel = in_par && (extent == EXT_NONE);
        mask     = {ROW_W{1'b1}} >> shift;
        base     = from_top ? ~mask : '0;

        st_d     = st_q;
        st_d.req = tick && !none_sel;
        if (st_d.req) begin
            st_d.row = base | (st_q.off & mask);
            st_d.off = st_q.off + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;
    assign row = st_q.row;

    // R10
    none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_par && extent == EXT_NONE) |=> (!req && $stable(st_q.off)));

    // R9
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !(in_par && extent == EXT_NONE)) |=> req);

    // R8
    low_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && in_par && !from_top && extent == EXT_EIGHTH)
        |=> (row[ROW_W-1 -: 3] == 3'b000));

endmodule

// File: rtl/psram_lp_ctrl.sv
module psram_lp_ctrl
    import psram_lp_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int LOW_CYCLES = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             sleep_n,
    input  logic             cfg_sleep_bit,
    input  logic [2:0]       cfg_extent,
    input  logic             cfg_from_top,
    input  logic             sw_cfg_wr,
    input  logic             sw_cfg_sleep,
    input  logic             refresh_tick,
    input  logic             rd_req,
    input  logic             wr_req,
    output logic [1:0]       mode,
    output logic             refresh_req,
    output logic [ROW_W-1:0] refresh_row,
    output logic             access_blocked,
    output logic             rd_go,
    output logic             wr_go
);
    logic  low_qualified;
    mode_e mode_q;
    logic  in_par;

    sleep_qual #(.LOW_CYCLES(LOW_CYCLES)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_n   (sleep_n),
        .qualified (low_qualified)
    );

    mode_ctrl u_mode (
        .clk           (clk),
        .rst_n         (rst_n),
        .ce_n          (ce_n),
        .sleep_n       (sleep_n),
        .cfg_sleep_bit (cfg_sleep_bit),
        .sw_cfg_wr     (sw_cfg_wr),
        .sw_cfg_sleep  (sw_cfg_sleep),
        .low_qualified (low_qualified),
        .mode          (mode_q)
    );

    assign in_par = (mode_q == MODE_PAR);

    refresh_gen #(.ROW_W(ROW_W)) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (refresh_tick),
        .in_par   (in_par),
        .extent   (cfg_extent),
        .from_top (cfg_from_top),
        .req      (refresh_req),
        .row      (refresh_row)
    );

    assign mode           = mode_q;
    assign access_blocked = in_par;
    assign rd_go          = rd_req && !in_par;
    assign wr_go          = wr_req && !in_par;

    // R3
    pin_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_par) && !$past(sw_cfg_wr)) |-> $past(low_qualified && !sleep_n && cfg_sleep_bit));

endmodule

// File: tb/psram_lp_ctrl_bench.sv
module psram_lp_ctrl_bench;
    localparam int ROW_W = 5;
    localparam int ROWS  = 1 << ROW_W;
    localparam int LOWC  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, sleep_n = 1'b1, cfg_sleep_bit = 1'b0, cfg_from_top = 1'b0;
    logic [2:0] cfg_extent = 3'b000;
    logic sw_cfg_wr = 1'b0, sw_cfg_sleep = 1'b0, refresh_tick = 1'b0;
    logic rd_req = 1'b0, wr_req = 1'b0;
    logic [1:0] mode;
    logic refresh_req, access_blocked, rd_go, wr_go;
    logic [ROW_W-1:0] refresh_row;

    int nchk = 0;
    int nfail = 0;
    int off = 0;

    always #2 clk = ~clk;

    psram_lp_ctrl #(.ROW_W(ROW_W), .LOW_CYCLES(LOWC)) u_psram_lp_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .sleep_n(sleep_n),
        .cfg_sleep_bit(cfg_sleep_bit), .cfg_extent(cfg_extent), .cfg_from_top(cfg_from_top),
        .sw_cfg_wr(sw_cfg_wr), .sw_cfg_sleep(sw_cfg_sleep), .refresh_tick(refresh_tick),
        .rd_req(rd_req), .wr_req(wr_req), .mode(mode), .refresh_req(refresh_req),
        .refresh_row(refresh_row), .access_blocked(access_blocked), .rd_go(rd_go), .wr_go(wr_go)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // one refresh tick, checked against the arithmetic model
    task automatic do_tick(input bit in_par, input string req);
        int sh;
        int size;
        int base;
        bit none;
        none = in_par && (cfg_extent == 3'b100);
        sh = 0;
        if (in_par && cfg_extent == 3'b001) sh = 1;
        if (in_par && cfg_extent == 3'b010) sh = 2;
        if (in_par && cfg_extent == 3'b011) sh = 3;
        size = ROWS >> sh;
        base = cfg_from_top ? ROWS - size : 0;
        refresh_tick = 1'b1;
        step();
        refresh_tick = 1'b0;
        if (none) begin
            chk({req, " R10 no request"}, int'(refresh_req), 0);
        end else begin
            chk({req, " R9 request"}, int'(refresh_req), 1);
            chk({req, " R7 R8 R9 row"}, int'(refresh_row), base + (off % size));
            off = (off + 1) % ROWS;
        end
    endtask

    task automatic hold_low(input int n);
        sleep_n = 1'b0;
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #400000;
        nfail++;
        nchk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 mode", int'(mode), 0);
        chk("R1 refresh_req", int'(refresh_req), 0);
        chk("R1 blocked", int'(access_blocked), 0);
        rst_n = 1'b1;
        step();
        // R2 standby / active
        chk("R2 standby", int'(mode), 1);
        ce_n = 1'b0; step();
        chk("R2 active ce low", int'(mode), 0);
        ce_n = 1'b1; sleep_n = 1'b0; step();
        chk("R2 active sleep low", int'(mode), 0);
        sleep_n = 1'b1; step();
        chk("R2 standby again", int'(mode), 1);
        rd_req = 1'b1; wr_req = 1'b1; #1;
        chk("R6 rd passes", int'(rd_go), 1);
        chk("R6 wr passes", int'(wr_go), 1);
        // full-array refresh outside PAR, extent ignored
        cfg_extent = 3'b011; cfg_from_top = 1'b1;
        for (int i = 0; i < 40; i++) do_tick(1'b0, "R2 full");
        // R4 sleep bit clear
        cfg_sleep_bit = 1'b0;
        hold_low(LOWC + 6);
        chk("R4 no PAR", int'(mode), 0);
        sleep_n = 1'b1; step();
        // R3 sweep over extents and anchors
        cfg_sleep_bit = 1'b1;
        for (int e = 0; e < 8; e++) begin
            for (int t = 0; t < 2; t++) begin
                cfg_extent = 3'(e); cfg_from_top = t[0];
                hold_low(LOWC);
                chk("R3 not yet PAR", int'(mode), 0);
                step();
                chk("R3 PAR", int'(mode), 2);
                chk("R6 blocked", int'(access_blocked), 1);
                chk("R6 rd blocked", int'(rd_go), 0);
                chk("R6 wr blocked", int'(wr_go), 0);
                for (int k = 0; k < 10; k++) do_tick(1'b1, "sweep");
                sleep_n = 1'b1; step();
                chk("R5 exit", int'(mode), 1);
                chk("R6 rd after exit", int'(rd_go), 1);
            end
        end
        // R11 software entry, R12 pin has no effect
        cfg_extent = 3'b001; cfg_from_top = 1'b0;
        sw_cfg_wr = 1'b1; sw_cfg_sleep = 1'b1; step();
        sw_cfg_wr = 1'b0;
        chk("R11 sw PAR", int'(mode), 2);
        step();
        chk("R12 sleep_n high keeps sw PAR", int'(mode), 2);
        do_tick(1'b1, "R11 sw");
        sw_cfg_sleep = 1'b0; sw_cfg_wr = 1'b1; step();
        sw_cfg_wr = 1'b0;
        chk("R11 sw exit", int'(mode), 1);
        hold_low(LOWC + 5);
        chk("R12 pin entry locked", int'(mode), 0);
        sleep_n = 1'b1; step();
        // reset restores pin entry
        rst_n = 1'b0; step();
        chk("R1 reset mode", int'(mode), 0);
        rst_n = 1'b1; off = 0; step();
        hold_low(LOWC + 1);
        chk("R1 R12 pin entry after reset", int'(mode), 2);
        sleep_n = 1'b1; step();
        chk("R5 exit after reset", int'(mode), 1);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule